// File: doc/BRIEF.md
# Lane-Partitioned Leading-Bit Counter

This block counts leading bits inside every lane of a 128-bit vector operand. At run time the operand is divided into lanes of 8, 16 or 32 bits. In each lane the block counts either the leading zero bits or the leading sign bits. Each count is written back into the same lane position of a 128-bit result.

A single shared tree does the work for all three lane widths. Every byte gets a small leading-zero counter. The byte counts are then merged pairwise into 16-bit and 32-bit counts. Sign-count mode reuses the same tree: each lane's bits are first XORed with that lane's top bit. A half-width select limits the work to the low 64 bits.

The result and a configuration-error flag are registered, so they appear one clock after the inputs are applied. Instruction decode, register access, traps and condition flags live elsewhere.

Top module: `lzc_vec_top`

## Requirements
- R1: The size code `esz_i` selects the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes and 2'b10 gives 32-bit lanes. Lane k occupies result bits [k*W +: W] and is computed only from operand bits [k*W +: W].
- R2: With `sign_mode_i` = 0, a lane's count is the number of consecutive zero bits starting at the lane's most significant bit. An all-zero lane yields the lane width.
- R3: With `sign_mode_i` = 1, a lane's count is the number of consecutive bits directly below the lane's most significant bit that equal that bit; the top bit itself is not counted. An all-zero or all-one lane yields the lane width minus 1.
- R4: Each count sits in the low bits of its lane, and the remaining upper bits of that lane are zero.
- R5: With `full_i` = 0, only operand bits [63:0] are processed, and `result_o[127:64]` is zero. With `full_i` = 1, all 128 bits are processed.
- R6: Size code 2'b11 is reserved. It sets `bad_cfg_o` to 1 and produces an all-zero result. For any other size code, `bad_cfg_o` is 0.
- R7: `result_o` and `bad_cfg_o` reflect the inputs that were present at the preceding rising clock edge, and stay unchanged between edges.
- R8: When `rst_n` is low at a rising edge, `result_o` and `bad_cfg_o` become zero on that edge (synchronous, active-low reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opnd_i | input | 128 | Vector operand |
| esz_i | input | 2 | Lane size code (00: 8-bit, 01: 16-bit, 10: 32-bit, 11: reserved) |
| full_i | input | 1 | 1: all 128 bits; 0: low 64 bits only |
| sign_mode_i | input | 1 | 0: count leading zeros; 1: count leading sign bits |
| result_o | output | 128 | Per-lane counts, registered |
| bad_cfg_o | output | 1 | Reserved size code was used, registered |

## Verification
Two functions can act on the same lane in the same cycle: sign-mode preprocessing, which XORs each bit with the lane's top bit, and half-width zeroing of the upper 64 bits. A third pairing is lane partitioning combined with the merge across a zero byte.

These pairings are provoked by applying every combination of size, half/full select and mode to the same operands. The operands are all-zero, all-one, single-bit and randomly masked lanes, so a count often has to cross a byte boundary.

Each registered result is judged one cycle later against a per-bit reference loop computed from the requirements. Directed cases cover reset, the reserved code and the one-cycle latency.

// File: rtl/lzc_pkg.sv
// Package: shared constants and the lane-size code for the leading-bit counter.
// Assumes: size code values are fixed by the requirements (00/01/10, 11 reserved).
package lzc_pkg;
    typedef enum logic [1:0] {
        ESZ_8   = 2'b00,
        ESZ_16  = 2'b01,
        ESZ_32  = 2'b10,
        ESZ_RSV = 2'b11
    } esz_t;
endpackage

// File: rtl/lzc_byte_count.sv
// Module: leading-zero counter for one W-bit slice.
// Assumes: W >= 1; the output can hold the value W (an all-zero slice).
module lzc_byte_count #(
    parameter int W  = 8,
    localparam int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  bits_i,
    output logic [CW-1:0] cnt_o
);
    logic seen;

    // Scan from the top bit and count zeros until the first one is seen.
    always_comb begin
        cnt_o = '0;
        seen  = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (bits_i[i]) seen = 1'b1;
                else           cnt_o = cnt_o + 1'b1;
            end
        end
    end

    // R2: the count reaches the full slice width exactly when the slice is empty.
    always_comb begin
        p_allzero_width_r2: assert ((cnt_o == CW'(W)) == (bits_i == '0));
    end
endmodule

// File: rtl/lzc_merge.sv
// Module: merges the leading-zero counts of two adjacent HALF_W-bit halves.
// Assumes: each input count is at most HALF_W; hi is the more significant half.
module lzc_merge #(
    parameter int HALF_W = 8,
    localparam int CW = $clog2(HALF_W) + 1
) (
    input  logic [CW-1:0] hi_cnt_i,
    input  logic [CW-1:0] lo_cnt_i,
    output logic [CW:0]   cnt_o
);
    logic hi_empty;

    // If the upper half is empty, its full width plus the lower count; otherwise the upper count.
    always_comb begin
        hi_empty = (hi_cnt_i == CW'(HALF_W));
        if (hi_empty) cnt_o = (CW + 1)'(HALF_W) + {1'b0, lo_cnt_i};
        else          cnt_o = {1'b0, hi_cnt_i};
    end

    // R2: a merged count never exceeds the width of both halves.
    always_comb begin
        p_merge_bound_r2: assert (cnt_o <= (CW + 1)'(2 * HALF_W));
    end
endmodule

// File: rtl/lzc_vec_top.sv
// Module: lane-partitioned leading-zero / leading-sign counter with registered outputs.
// Assumes: VEC_W is a multiple of 4*BYTE_W; lanes are 1, 2 or 4 bytes wide;
//          synchronous active-low reset; one-cycle latency from inputs to outputs.
module lzc_vec_top
    import lzc_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] opnd_i,
    input  logic [1:0]       esz_i,
    input  logic             full_i,
    input  logic             sign_mode_i,
    output logic [VEC_W-1:0] result_o,
    output logic             bad_cfg_o
);
    localparam int NB  = VEC_W / BYTE_W;
    localparam int NH  = NB / 2;
    localparam int NW  = NB / 4;
    localparam int H_W = 2 * BYTE_W;
    localparam int W_W = 4 * BYTE_W;
    localparam int C8  = $clog2(BYTE_W) + 1;
    localparam int C16 = C8 + 1;
    localparam int C32 = C8 + 2;

    logic [BYTE_W-1:0] xbyte [NB];
    logic [C8-1:0]     c8    [NB];
    logic [C16-1:0]    c16   [NH];
    logic [C32-1:0]    c32   [NW];
    logic [VEC_W-1:0]  nxt_result;
    logic              nxt_bad;

    // Per byte: pick the top bit of the enclosing lane and (in sign mode) XOR the byte with it.
    for (genvar b = 0; b < NB; b++) begin : g_byte
        localparam int MSB8  = b * BYTE_W + BYTE_W - 1;
        localparam int MSB16 = (b | 1) * BYTE_W + BYTE_W - 1;
        localparam int MSB32 = (b | 3) * BYTE_W + BYTE_W - 1;
        logic lane_msb;

        // Select the lane's top bit according to the lane size.
        always_comb begin
            case (esz_i)
                ESZ_16:  lane_msb = opnd_i[MSB16];
                ESZ_32:  lane_msb = opnd_i[MSB32];
                default: lane_msb = opnd_i[MSB8];
            endcase
            xbyte[b] = opnd_i[b*BYTE_W +: BYTE_W] ^ {BYTE_W{sign_mode_i & lane_msb}};
        end

        lzc_byte_count #(.W(BYTE_W)) u_cnt (
            .bits_i (xbyte[b]),
            .cnt_o  (c8[b])
        );
    end

    // First merge level: byte pairs into 16-bit counts.
    for (genvar h = 0; h < NH; h++) begin : g_half
        lzc_merge #(.HALF_W(BYTE_W)) u_m16 (
            .hi_cnt_i (c8[2*h+1]),
            .lo_cnt_i (c8[2*h]),
            .cnt_o    (c16[h])
        );
    end

    // Second merge level: 16-bit pairs into 32-bit counts.
    for (genvar w = 0; w < NW; w++) begin : g_word
        lzc_merge #(.HALF_W(H_W)) u_m32 (
            .hi_cnt_i (c16[2*w+1]),
            .lo_cnt_i (c16[2*w]),
            .cnt_o    (c32[w])
        );
    end

    // Pack the lane counts, minus one in sign mode, zeroing the upper half when full_i is low.
    always_comb begin
        nxt_result = '0;
        nxt_bad    = (esz_i == ESZ_RSV);
        case (esz_i)
            ESZ_8: begin
                for (int b = 0; b < NB; b++) begin
                    if (full_i || b < NB / 2)
                        nxt_result[b*BYTE_W +: BYTE_W] =
                            BYTE_W'(c8[b]) - BYTE_W'(sign_mode_i);
                end
            end
            ESZ_16: begin
                for (int h = 0; h < NH; h++) begin
                    if (full_i || h < NH / 2)
                        nxt_result[h*H_W +: H_W] =
                            H_W'(c16[h]) - H_W'(sign_mode_i);
                end
            end
            ESZ_32: begin
                for (int w = 0; w < NW; w++) begin
                    if (full_i || w < NW / 2)
                        nxt_result[w*W_W +: W_W] =
                            W_W'(c32[w]) - W_W'(sign_mode_i);
                end
            end
            default: nxt_result = '0;
        endcase
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            bad_cfg_o <= 1'b0;
        end else begin
            result_o  <= nxt_result;
            bad_cfg_o <= nxt_bad;
        end
    end

    // R6: the reserved size code yields the flag and an all-zero result on the next edge.
    p_rsv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (esz_i == ESZ_RSV) |=> (bad_cfg_o && result_o == '0));

    // R6: a legal size code never raises the flag.
    p_legal_noflag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (esz_i != ESZ_RSV) |=> !bad_cfg_o);

    // R5: half-width operation leaves the upper half of the result clear.
    p_half_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_i) |=> (result_o[VEC_W-1:VEC_W/2] == '0));

    // R7: an output register holds while its inputs hold.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(opnd_i) && $stable(esz_i) && $stable(full_i) && $stable(sign_mode_i))
        |=> $stable(result_o));

    for (genvar b = 0; b < NB; b++) begin : g_chk
        // R2, R4: an 8-bit zero count never exceeds the lane width.
        p_zero_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (esz_i == ESZ_8 && !sign_mode_i) |=>
            (result_o[b*BYTE_W +: BYTE_W] <= BYTE_W));
        // R3: an 8-bit sign count never exceeds lane width minus one.
        p_sign_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (esz_i == ESZ_8 && sign_mode_i) |=>
            (result_o[b*BYTE_W +: BYTE_W] <= BYTE_W - 1));
    end
endmodule

// File: tb/tb_lzc_vec_top.sv
`timescale 1ns/1ps
module tb_lzc_vec_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] opnd = '0;
    logic [1:0]   esz = 2'b00;
    logic         full = 1'b1;
    logic         smode = 1'b0;
    logic [127:0] result;
    logic         bad_cfg;

    int n_cmp = 0;
    int n_bad = 0;

    lzc_vec_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .opnd_i      (opnd),
        .esz_i       (esz),
        .full_i      (full),
        .sign_mode_i (smode),
        .result_o    (result),
        .bad_cfg_o   (bad_cfg)
    );

    always #2.5 clk = ~clk;

    // Stimulus table: operand and {esz, full, sign_mode}.
    localparam int NT = 8;
    localparam logic [127:0] T_OP [NT] = '{
        128'h0,
        {128{1'b1}},
        {16{8'h01}},
        128'h8000_0000_0040_0000_00FF_0001_7FFF_0F00,
        128'hFFFF_FFFE_0000_0001_C000_0000_3FFF_FFFF,
        128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
        128'h00FF_FF00_F0F0_0F0F_8001_0180_7E7E_8181,
        128'hFFFF_0000_FFFF_0000_0000_8000_0000_0001
    };
    localparam logic [3:0] T_CFG [NT] = '{
        4'b0010, 4'b1011, 4'b0110, 4'b0011,
        4'b1001, 4'b0100, 4'b0111, 4'b1111
    };

    // Reference: per-bit loop built from R1..R6.
    function automatic logic [127:0] ref_res(input logic [127:0] op, input logic [1:0] sz,
                                             input logic q, input logic md);
        logic [127:0] r;
        int w;
        r = '0;
        if (sz == 2'b11) return r;
        w = 8 << sz;
        for (int l = 0; l < 128 / w; l++) begin
            int  cnt;
            int  j;
            logic top;
            logic tgt;
            logic stop;
            if (!q && l * w >= 64) continue;
            top  = op[l*w + w - 1];
            tgt  = md ? top : 1'b0;
            j    = md ? w - 2 : w - 1;
            cnt  = 0;
            stop = 1'b0;
            while (j >= 0 && !stop) begin
                if (op[l*w + j] == tgt) begin
                    cnt++;
                    j--;
                end else begin
                    stop = 1'b1;
                end
            end
            for (int k = 0; k < w; k++) r[l*w + k] = (k < 32) ? cnt[k] : 1'b0;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] exp_r, input logic exp_b);
        n_cmp++;
        if (result !== exp_r || bad_cfg !== exp_b) begin
            n_bad++;
            $display("FAIL %s: result=%h bad=%b expected result=%h bad=%b",
                     req, result, bad_cfg, exp_r, exp_b);
        end
    endtask

    // Drive at a falling edge, let one rising edge register it, sample at the next falling edge.
    task automatic apply(input logic [127:0] op, input logic [1:0] sz, input logic q,
                         input logic md, input string req);
        @(negedge clk);
        opnd = op; esz = sz; full = q; smode = md;
        @(negedge clk);
        check(req, ref_res(op, sz, q, md), sz == 2'b11);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish (actual=timeout expected=done)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        // R8: reset clears outputs even with a reserved code on the inputs.
        opnd = {128{1'b1}}; esz = 2'b11; full = 1'b1; smode = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 reset", 128'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 reserved code", 128'h0, 1'b1);

        // R1-style table walk: each entry is checked against the reference.
        for (int t = 0; t < NT; t++)
            apply(T_OP[t], T_CFG[t][3:2], T_CFG[t][1], T_CFG[t][0], "R1 table");

        // R2: all-zero 8-bit lanes give 8.
        apply(128'h0, 2'b00, 1'b1, 1'b0, "R2 zero lanes");
        check("R2 zero lanes literal", {16{8'h08}}, 1'b0);
        // R3: all-one 32-bit lanes in sign mode give 31.
        apply({128{1'b1}}, 2'b10, 1'b1, 1'b1, "R3 ones lanes");
        check("R3 ones literal", {4{32'h0000_001F}}, 1'b0);
        // R4: single-bit 16-bit lanes give 15 with upper lane bits clear.
        apply({8{16'h0001}}, 2'b01, 1'b1, 1'b0, "R4 single bit");
        check("R4 single bit literal", {8{16'h000F}}, 1'b0);
        // R5: half width clears the upper 64 bits.
        apply(128'h0, 2'b00, 1'b0, 1'b0, "R5 half width");
        check("R5 half literal", {64'h0, {8{8'h08}}}, 1'b0);
        // R6: reserved code in half mode still yields zero and the flag.
        apply({128{1'b1}}, 2'b11, 1'b0, 1'b1, "R6 reserved half");

        // R7: output holds until the next rising edge, then updates.
        @(negedge clk);
        opnd = 128'h0; esz = 2'b10; full = 1'b1; smode = 1'b0;
        @(negedge clk);
        opnd = {4{32'h0000_8000}};
        #1;
        check("R7 hold before edge", {4{32'h0000_0020}}, 1'b0);
        @(negedge clk);
        check("R7 update after edge", {4{32'h0000_0010}}, 1'b0);

        // R1, R2, R3, R5: random operands with random leading zeros across every configuration.
        for (int c = 0; c < 16; c++) begin
            for (int n = 0; n < 20; n++) begin
                logic [127:0] op;
                for (int k = 0; k < 4; k++) begin
                    logic [31:0] v;
                    v = $urandom;
                    v = v >> ($urandom % 33);
                    if ($urandom % 3 == 0) v = ~v;
                    op[k*32 +: 32] = v;
                end
                apply(op, c[3:2], c[1], c[0], "R1 random");
            end
        end

        // R8: reset mid-run clears a nonzero result.
        @(negedge clk);
        opnd = 128'h0; esz = 2'b00; full = 1'b1; smode = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 mid-run reset", 128'h0, 1'b0);
        rst_n = 1'b1;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule